// File: doc/BRIEF.md
# Divider-Clocked Programmable Timer

The block has a free-running internal divider and a programmable 8-bit counter. The divider advances by a fixed amount on every machine-cycle step strobe. A control register enables counting and chooses which divider bit acts as the counter's clock. The counter advances when that bit goes from high to low. A reload register supplies the value the counter takes when it wraps. One step later, a single-cycle interrupt request is raised.

The counter clock is the logical AND of the enable bit and the chosen divider bit. So any event that drops this AND from 1 to 0 also advances the counter once. Such events include a divider clear or a control write that disables counting or moves the tap to a low bit. A higher divider bit drives two strobes for an external audio sequencer: one when it falls and one when it rises. A stop input freezes the divider and the counter. A small register port gives access from a host: write enable, 2-bit address, and a combinational read.

Top module: `tmr_unit`

## Requirements
- R1: Each clock with `step_i` high and `stop_i` low adds 4 to the 16-bit divider. A read at address 0 returns divider bits 15:8.
- R2: A write to address 0, with any data, clears the whole divider. If the enabled tap bit was 1 before the clear, the counter advances by exactly one.
- R3: Control register bit 2 enables counting. Bits 1:0 choose the tap: 00 selects divider bit 9, 01 bit 3, 10 bit 5, 11 bit 7. The counter (address 1) advances by one each time the enabled tap falls from 1 to 0, and never while counting is disabled.
- R4: When an advance would take the counter past 0xFF, it takes the reload register value (address 2) in that same clock.
- R5: `irq_o` is high for exactly one clock. This is the clock after the first step that follows the wrapping step. No further request comes from that wrap.
- R6: A control write advances the counter by one when the old setting was enabled with its tap at 1, and the new setting is either disabled or has its tap at 0. Otherwise a control write does not advance the counter.
- R7: Addresses 1, 2 and 3 are counter, reload and control. They read back what was written, and control reads as its 3 low bits with the upper bits zero.
- R8: While `stop_i` is high, steps change neither the divider nor the counter.
- R9: `seq_evt_o` pulses for one clock after divider bit 12 falls (bit 13 when `dbl_speed_i` is high). `seq_aux_o` pulses for one clock after that bit rises.
- R10: After reset every register reads zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Machine-cycle step strobe |
| stop_i | input | 1 | Freezes divider and counter |
| dbl_speed_i | input | 1 | Moves sequencer tap one bit higher |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request pulse |
| seq_evt_o | output | 1 | Sequencer falling-edge strobe |
| seq_aux_o | output | 1 | Sequencer rising-edge strobe |

## Verification
The bench builds the block with its defaults: a 16-bit divider, an 8-bit counter, a step size of 4, and the sequencer tap at bit 12. With these values every tap period is short in steps. Bit 3 falls every 4 steps, and bit 9 falls every 256. The sequencer bit needs 1024 steps to rise and 2048 to fall, and its double-speed variant needs 2048 to rise. As a result, every tap choice, the wrap-and-reload sequence and both sequencer edges in both speed modes can be reached in a few thousand clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {RL_RUN, RL_LOADING, RL_LOADED} rl_state_e;

  localparam logic [1:0] A_DIV = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_RLD = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  // tap choice -> divider bit index (00:9, 01:3, 10:5, 11:7)
  function automatic int unsigned tap_index(input logic [1:0] sel);
    case (sel)
      2'b00:   return 9;
      2'b01:   return 3;
      2'b10:   return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/tmr_div.sv
module tmr_div #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned STEP_INC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic [DIV_W-1:0] div_n_o
);
  localparam logic [DIV_W-1:0] INC = DIV_W'(STEP_INC);

  logic [DIV_W-1:0] div_q;

  always_comb begin
    if (clr_i)      div_n_o = '0;
    else if (adv_i) div_n_o = div_q + INC;
    else            div_n_o = div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_n_o;
  end

  assign div_q_o = div_q;
endmodule

// File: rtl/tmr_tap.sv
module tmr_tap #(
  parameter int unsigned DIV_W = 16
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [2:0]       ctl_i,
  output logic             tap_o
);
  import tmr_pkg::*;
  localparam int unsigned IW = $clog2(DIV_W);

  logic [IW-1:0] idx;

  assign idx   = IW'(tap_index(ctl_i[1:0]));
  assign tap_o = ctl_i[2] & div_i[idx];
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             inc_i,
  input  logic             cnt_wr_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             irq_o
);
  import tmr_pkg::*;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, rld_q, rld_n;
  rl_state_e        st_q;
  logic             irq_q;

  assign rld_n = rld_wr_i ? wdata_i : rld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      st_q  <= RL_RUN;
      irq_q <= 1'b0;
    end else begin
      irq_q <= adv_i && (st_q == RL_LOADING);
      rld_q <= rld_n;
      if (adv_i) begin
        case (st_q)
          RL_LOADING: st_q <= RL_LOADED;
          RL_LOADED:  st_q <= RL_RUN;
          default:    st_q <= RL_RUN;
        endcase
      end
      if (cnt_wr_i) begin
        cnt_q <= wdata_i;
      end else if (inc_i) begin
        if (&cnt_q) begin
          cnt_q <= rld_n;
          st_q  <= RL_LOADING;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned SEQ_BIT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_i,
  input  logic [DIV_W-1:0] div_q_i,
  input  logic [DIV_W-1:0] div_n_i,
  output logic             fall_o,
  output logic             rise_o
);
  logic cur, nxt, fall_q, rise_q;

  generate
    if (SEQ_BIT + 1 < DIV_W) begin : g_two
      assign cur = dbl_i ? div_q_i[SEQ_BIT+1] : div_q_i[SEQ_BIT];
      assign nxt = dbl_i ? div_n_i[SEQ_BIT+1] : div_n_i[SEQ_BIT];
    end else begin : g_one
      assign cur = div_q_i[SEQ_BIT];
      assign nxt = div_n_i[SEQ_BIT];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= cur & ~nxt;
      rise_q <= ~cur & nxt;
    end
  end

  assign fall_o = fall_q;
  assign rise_o = rise_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STEP_INC = 4,
  parameter int unsigned SEQ_BIT  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             stop_i,
  input  logic             dbl_speed_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             seq_evt_o,
  output logic             seq_aux_o
);
  import tmr_pkg::*;

  logic             adv, div_clr, ctl_wr, cnt_wr, rld_wr;
  logic [DIV_W-1:0] div_q, div_n;
  logic [2:0]       ctl_q, ctl_n;
  logic             tap_cur, tap_nxt, inc;
  logic [CNT_W-1:0] cnt_q, rld_q;

  assign adv     = step_i & ~stop_i;
  assign div_clr = wr_en_i && addr_i == A_DIV;
  assign cnt_wr  = wr_en_i && addr_i == A_CNT;
  assign rld_wr  = wr_en_i && addr_i == A_RLD;
  assign ctl_wr  = wr_en_i && addr_i == A_CTL;
  assign ctl_n   = ctl_wr ? wdata_i[2:0] : ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_n;
  end

  tmr_div #(.DIV_W(DIV_W), .STEP_INC(STEP_INC)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .clr_i(div_clr),
    .div_q_o(div_q), .div_n_o(div_n)
  );

  // tap seen before and after this clock; a 1->0 drop of either cause advances
  tmr_tap #(.DIV_W(DIV_W)) u_tap_cur (.div_i(div_q), .ctl_i(ctl_q), .tap_o(tap_cur));
  tmr_tap #(.DIV_W(DIV_W)) u_tap_nxt (.div_i(div_n), .ctl_i(ctl_n), .tap_o(tap_nxt));

  assign inc = tap_cur & ~tap_nxt;

  tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .inc_i(inc),
    .cnt_wr_i(cnt_wr), .rld_wr_i(rld_wr), .wdata_i(wdata_i),
    .cnt_o(cnt_q), .rld_o(rld_q), .irq_o(irq_o)
  );

  tmr_seq #(.DIV_W(DIV_W), .SEQ_BIT(SEQ_BIT)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .dbl_i(dbl_speed_i),
    .div_q_i(div_q), .div_n_i(div_n), .fall_o(seq_evt_o), .rise_o(seq_aux_o)
  );

  always_comb begin
    case (addr_i)
      A_DIV:   rdata_o = div_q[DIV_W-1 -: CNT_W];
      A_CNT:   rdata_o = cnt_q;
      A_RLD:   rdata_o = rld_q;
      default: rdata_o = {{(CNT_W-3){1'b0}}, ctl_q};
    endcase
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STEP_INC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic             stop_i,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic             irq_o,
  input logic             seq_evt_o,
  input logic             seq_aux_o,
  input logic [DIV_W-1:0] div_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q
);
  import tmr_pkg::*;

  AST_DIV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !stop_i && !(wr_en_i && addr_i == A_DIV) |=> div_q == DIV_W'($past(div_q) + STEP_INC)); // R1
  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_DIV |=> div_q == '0); // R2
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R5
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !wr_en_i |=> $stable(div_q) && $stable(cnt_q)); // R8
  AST_CNT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1) || cnt_q == $past(rld_q)); // R4
  AST_SEQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_evt_o && seq_aux_o)); // R9
endmodule

bind tmr_unit tmr_unit_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W), .STEP_INC(STEP_INC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .stop_i(stop_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .irq_o(irq_o),
  .seq_evt_o(seq_evt_o), .seq_aux_o(seq_aux_o),
  .div_q(div_q), .cnt_q(cnt_q), .rld_q(rld_q)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  ctl;
    logic [15:0] steps;
    logic [7:0]  exp_cnt;
  } vec_t;

  // counter advances = floor(4*steps / 2^(tap+1)) when enabled (R3)
  localparam vec_t VECS [6] = '{
    '{3'b101, 16'd10,  8'd2},
    '{3'b110, 16'd40,  8'd2},
    '{3'b111, 16'd130, 8'd2},
    '{3'b100, 16'd300, 8'd1},
    '{3'b001, 16'd20,  8'd0},
    '{3'b101, 16'd70,  8'd17}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0, stop_i = 1'b0, dbl_speed_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o, seq_evt_o, seq_aux_o;

  int n_chk = 0, n_err = 0;
  int n_evt = 0, n_aux = 0, n_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .stop_i(stop_i),
    .dbl_speed_i(dbl_speed_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .seq_evt_o(seq_evt_o), .seq_aux_o(seq_aux_o)
  );

  always @(negedge clk) begin
    if (seq_evt_o) n_evt++;
    if (seq_aux_o) n_aux++;
    if (irq_o)     n_irq++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic run(input int n);
    step_i = 1'b1;
    repeat (n) @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic setup(input logic [2:0] ctl);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd3, {5'd0, ctl});
  endtask

  task automatic clear_counts();
    @(negedge clk); #1;
    n_evt = 0; n_aux = 0; n_irq = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R10 reg", v, 0);
    end
    chk("R10 irq", irq_o, 0);
    chk("R10 seq", seq_evt_o | seq_aux_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 tap table
    foreach (VECS[i]) begin
      setup(VECS[i].ctl);
      run(int'(VECS[i].steps));
      rd(2'd1, v); chk("R3 tap count", v, int'(VECS[i].exp_cnt));
    end

    // R1 divider read
    setup(3'b000);
    run(64);
    rd(2'd0, v); chk("R1 div upper", v, 1);
    run(960);
    rd(2'd0, v); chk("R1 div upper 1024", v, 16);

    // R7 register readback
    wr(2'd2, 8'h5A); rd(2'd2, v); chk("R7 reload", v, 8'h5A);
    wr(2'd1, 8'hC3); rd(2'd1, v); chk("R7 counter", v, 8'hC3);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R7 control", v, 7);

    // R2 divider clear with tap high
    setup(3'b101); run(2);
    wr(2'd0, 8'h77);
    rd(2'd1, v); chk("R2 clear advance", v, 1);
    rd(2'd0, v); chk("R2 div zero", v, 0);

    // R6 glitch cases
    setup(3'b101); run(2); wr(2'd3, 8'h01);
    rd(2'd1, v); chk("R6 disable", v, 1);
    setup(3'b101); run(2); wr(2'd3, 8'h06);
    rd(2'd1, v); chk("R6 tap low", v, 1);
    setup(3'b101); run(10); wr(2'd3, 8'h06);
    rd(2'd1, v); chk("R6 tap high no advance", v, 2);
    setup(3'b001); run(2); wr(2'd3, 8'h05);
    rd(2'd1, v); chk("R6 old disabled", v, 0);

    // R4 / R5 wrap, reload, delayed request
    setup(3'b000);
    wr(2'd2, 8'hA0); wr(2'd1, 8'hFF); wr(2'd3, 8'h05);
    clear_counts();
    run(3);
    rd(2'd1, v); chk("R4 before wrap", v, 8'hFF);
    run(1);
    rd(2'd1, v); chk("R4 reload", v, 8'hA0);
    chk("R5 no irq on wrap step", irq_o, 0);
    @(negedge clk);
    chk("R5 no irq without step", irq_o, 0);
    run(1);
    chk("R5 irq after next step", irq_o, 1);
    run(1);
    chk("R5 irq one clock", irq_o, 0);
    run(4);
    #1; chk("R5 irq total", n_irq, 1);
    rd(2'd1, v); chk("R4 continue", v, 8'hA1);

    // R8 stop
    setup(3'b101); run(3);
    stop_i = 1'b1; run(300); stop_i = 1'b0;
    rd(2'd0, v); chk("R8 div frozen", v, 0);
    rd(2'd1, v); chk("R8 cnt frozen", v, 0);
    run(1);
    rd(2'd1, v); chk("R8 resume", v, 1);

    // R9 sequencer, normal speed
    setup(3'b000);
    clear_counts();
    run(1024);
    #1; chk("R9 rise", n_aux, 1); chk("R9 no fall yet", n_evt, 0);
    run(1024);
    #1; chk("R9 fall", n_evt, 1);
    // R9 double speed
    dbl_speed_i = 1'b1;
    wr(2'd0, 8'h00);
    clear_counts();
    run(2048);
    #1; chk("R9 dbl rise", n_aux, 1); chk("R9 dbl no fall", n_evt, 0);
    wr(2'd0, 8'h00);
    clear_counts();
    chk("R9 clear fall", n_evt, 0);
    dbl_speed_i = 1'b0;
    wr(2'd0, 8'h00); run(1024);
    clear_counts();
    wr(2'd0, 8'h00);
    @(negedge clk); #1;
    chk("R9 clear fall pulse", n_evt, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule